// File: doc/BRIEF.md
# Byte Rotate Execution Unit

This block runs two byte-wide rotate operations for a small 8-bit accumulator processor. The first turns a data byte one place towards the MSB and brings the old MSB around into bit 0, leaving the carry alone. The second turns a data byte one place towards the LSB through the carry flag. The unit receives a 16-bit instruction word on a one-cycle `start` pulse. It decodes the opcode and forms a 12-bit data-memory address. It then reads the operand over a synchronous register-file port, rotates it, and writes the result either into its working register W or back to the same file address. It also updates the N, Z and C status flags.

Address formation depends on the bank-access bit and on an extended-mode input. With the bit set, the bank number input supplies the upper address bits. With the bit clear, the address comes from a split access window. With the bit clear, extended mode on and a small file address, the address is instead a literal offset added to the index pointer `fsr2`.

The work is sequenced by a state machine with five states.
- IDLE waits for `start`. The transition IDLE→DECODE happens on `start`, and the instruction word is latched at that point.
- DECODE checks the opcode. It goes to READ on a legal opcode. On an illegal opcode it goes back to IDLE and raises `illegal`.
- READ issues the read and always moves on to PROCESS.
- PROCESS captures the read data and the rotated result, then moves on to WRITE.
- WRITE commits the result and moves on to IDLE.

Top module: `rot_unit`

## Requirements
- R1: `instr[15:10]` = 6'b010001 selects rotate-left-without-carry, and `instr[15:10]` = 6'b001100 selects rotate-right-through-carry. In both, bit 9 is the destination bit d, bit 8 is the access bit a, and bits 7:0 are the file address f.
- R2: Rotate-left gives result = {x[6:0], x[7]}. It sets N to result bit 7 and Z to (result == 0), and leaves C unchanged.
- R3: Rotate-right gives result = {C_old, x[7:1]}. It sets C to x[0], N to result bit 7 and Z to (result == 0).
- R4: With d=0 the result goes to W and no register-file write occurs. With d=1 the result is written to the address the operand was read from, and W keeps its value.
- R5: With a=1 the address is {bsr[3:0], f}.
- R6: With a=0 and no indexed addressing, f < 8'h60 maps to {4'h0, f} and f ≥ 8'h60 maps to {4'hF, f}.
- R7: With a=0, `ext_mode`=1 and f ≤ 8'h5F, the address is (fsr2 + f) truncated to 12 bits. With the same settings and f ≥ 8'h60, the R6 mapping applies.
- R8: After `start` is seen in IDLE, the unit spends exactly one cycle in each of DECODE, READ, PROCESS and WRITE. `rf_re` is high only in READ. `rf_we` and `done` are high only in WRITE. `busy` is high in every state except IDLE. `start` has no effect while busy.
- R9: Any other opcode raises `illegal` for the DECODE cycle and returns to IDLE. It causes no read and no write, and W and the status flags stay unchanged.
- R10: Reset clears W and the status flags to zero and leaves the unit in IDLE. `status_out` bit 0 is C, bit 1 is Z and bit 2 is N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction valid pulse (taken in IDLE only) |
| instr | input | 16 | Instruction word |
| ext_mode | input | 1 | Enables indexed literal offset addressing |
| bsr | input | 4 | Bank number for banked access |
| fsr2 | input | 12 | Index pointer for literal offset addressing |
| rf_addr | output | 12 | Register-file address |
| rf_re | output | 1 | Register-file read strobe (data valid next cycle) |
| rf_rdata | input | 8 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 8 | Register-file write data |
| w_out | output | 8 | Working register W |
| status_out | output | 3 | {N, Z, C} |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Commit cycle of a legal instruction |
| illegal | output | 1 | Unrecognised opcode seen in DECODE |

## Verification
The hardest case to reach is rotate-right with a chosen incoming carry. No port sets C directly, so C can only be loaded by the unit's own rotate-right. Before each case, the bench therefore runs a rotate-right into W on a scratch byte that holds the wanted carry in bit 0. It then sweeps every operand value with both carry values.

The bench also has to reach two address edges, f = 5Fh/60h and an index pointer near the top of the 12-bit space. It does this by setting `fsr2`, `ext_mode` and `bsr` beside the instruction. It then checks which bench-side memory byte changed.

// File: rtl/rot_pkg.sv
package rot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_READ,
        ST_PROC,
        ST_WRITE
    } rot_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_RLNC,
        OP_RRC
    } rot_op_e;

    localparam logic [5:0] PFX_RLNC = 6'b010001;
    localparam logic [5:0] PFX_RRC  = 6'b001100;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
    } rot_flags_t;

endpackage

// File: rtl/rot_decode.sv
module rot_decode
    import rot_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int FADDR_W = 8
) (
    input  logic [INSTR_W-1:0] instr,
    output rot_op_e            op,
    output logic               dest_f,
    output logic               acc_sel,
    output logic [FADDR_W-1:0] faddr
);
    localparam int PFX_LSB = INSTR_W - 6;

    always_comb begin
        unique case (instr[INSTR_W-1:PFX_LSB])
            PFX_RLNC: op = OP_RLNC;
            PFX_RRC:  op = OP_RRC;
            default:  op = OP_NONE;
        endcase
    end

    assign dest_f  = instr[FADDR_W+1];
    assign acc_sel = instr[FADDR_W];
    assign faddr   = instr[FADDR_W-1:0];

endmodule

// File: rtl/rot_addr_gen.sv
module rot_addr_gen #(
    parameter int                FADDR_W = 8,
    parameter int                BANK_W  = 4,
    parameter logic [FADDR_W-1:0] SPLIT  = 8'h60,
    localparam int               ADDR_W  = BANK_W + FADDR_W
) (
    input  logic               acc_sel,
    input  logic               ext_mode,
    input  logic [FADDR_W-1:0] faddr,
    input  logic [BANK_W-1:0]  bsr,
    input  logic [ADDR_W-1:0]  fsr2,
    output logic [ADDR_W-1:0]  addr
);
    localparam logic [BANK_W-1:0] BANK_LO = '0;
    localparam logic [BANK_W-1:0] BANK_HI = '1;

    logic             low_half;
    logic [ADDR_W-1:0] idx_sum;
    logic [ADDR_W-1:0] win_addr;

    assign low_half = (faddr < SPLIT);
    assign idx_sum  = fsr2 + {BANK_LO, faddr};
    assign win_addr = low_half ? {BANK_LO, faddr} : {BANK_HI, faddr};

    always_comb begin
        if (acc_sel)
            addr = {bsr, faddr};
        else if (ext_mode && low_half)
            addr = idx_sum;
        else
            addr = win_addr;
    end

endmodule

// File: rtl/rot_alu.sv
module rot_alu
    import rot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rot_op_e           op,
    input  logic [DATA_W-1:0] din,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output rot_flags_t        flags
);
    logic [DATA_W-1:0] rl;
    logic [DATA_W-1:0] rr;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign rl[(i + 1) % DATA_W] = din[i];
        if (i > 0) begin : g_rr
            assign rr[i-1] = din[i];
        end
    end
    assign rr[DATA_W-1] = cin;

    always_comb begin
        unique case (op)
            OP_RLNC: begin
                res     = rl;
                flags.c = cin;
            end
            OP_RRC: begin
                res     = rr;
                flags.c = din[0];
            end
            default: begin
                res     = din;
                flags.c = cin;
            end
        endcase
        flags.n = res[DATA_W-1];
        flags.z = (res == '0);
    end

endmodule

// File: rtl/rot_unit.sv
module rot_unit
    import rot_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BANK_W  = 4,
    parameter int INSTR_W = 16,
    localparam int ADDR_W = BANK_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic               ext_mode,
    input  logic [BANK_W-1:0]  bsr,
    input  logic [ADDR_W-1:0]  fsr2,
    output logic [ADDR_W-1:0]  rf_addr,
    output logic               rf_re,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic               rf_we,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic [DATA_W-1:0]  w_out,
    output logic [2:0]         status_out,
    output logic               busy,
    output logic               done,
    output logic               illegal
);
    rot_state_e         state_q, state_d;
    logic [INSTR_W-1:0] instr_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  res_q;
    rot_flags_t         flg_q;
    logic [DATA_W-1:0]  w_q;
    rot_flags_t         status_q;

    rot_op_e            op;
    logic               dest_f;
    logic               acc_sel;
    logic [DATA_W-1:0]  faddr;
    logic [ADDR_W-1:0]  addr_calc;
    logic [DATA_W-1:0]  alu_res;
    rot_flags_t         alu_flags;

    rot_decode #(.INSTR_W(INSTR_W), .FADDR_W(DATA_W)) i_dec (
        .instr   (instr_q),
        .op      (op),
        .dest_f  (dest_f),
        .acc_sel (acc_sel),
        .faddr   (faddr)
    );

    rot_addr_gen #(.FADDR_W(DATA_W), .BANK_W(BANK_W)) i_addr (
        .acc_sel  (acc_sel),
        .ext_mode (ext_mode),
        .faddr    (faddr),
        .bsr      (bsr),
        .fsr2     (fsr2),
        .addr     (addr_calc)
    );

    rot_alu #(.DATA_W(DATA_W)) i_alu (
        .op    (op),
        .din   (rf_rdata),
        .cin   (status_q.c),
        .res   (alu_res),
        .flags (alu_flags)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_DECODE;
            ST_DECODE: state_d = (op == OP_NONE) ? ST_IDLE : ST_READ;
            ST_READ:   state_d = ST_PROC;
            ST_PROC:   state_d = ST_WRITE;
            ST_WRITE:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q  <= '0;
            addr_q   <= '0;
            res_q    <= '0;
            flg_q    <= '0;
            w_q      <= '0;
            status_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start) instr_q <= instr;
                ST_READ:  addr_q <= addr_calc;
                ST_PROC: begin
                    res_q <= alu_res;
                    flg_q <= alu_flags;
                end
                ST_WRITE: begin
                    if (!dest_f) w_q <= res_q;
                    status_q <= flg_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rf_re   = 1'b0;
        rf_we   = 1'b0;
        done    = 1'b0;
        illegal = 1'b0;
        busy    = 1'b1;
        rf_addr = addr_calc;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_DECODE: illegal = (op == OP_NONE);
            ST_READ:   rf_re = 1'b1;
            ST_PROC:   rf_addr = addr_q;
            ST_WRITE: begin
                rf_addr = addr_q;
                rf_we   = dest_f;
                done    = 1'b1;
            end
            default: ;
        endcase
    end

    assign rf_wdata   = res_q;
    assign w_out      = w_q;
    assign status_out = status_q;

    // R8: a write lands exactly two cycles after the read strobe
    p_we_after_re_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(rf_re, 2));

    // R8: the commit cycle is followed by IDLE
    p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R4: write-back targets the address that was read
    p_we_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_addr == $past(rf_addr, 2));

    // R4: file destination keeps W
    p_w_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rf_we) |=> $stable(w_out));

    // R2: left rotate keeps carry
    p_rlnc_keeps_c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op == OP_RLNC) |=> status_out[0] == $past(status_out[0]));

    // R9: illegal opcode leaves architectural state and returns to IDLE
    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (!busy && $stable(w_out) && $stable(status_out)));

endmodule

// File: tb/test_rot_unit.sv
module test_rot_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic        ext_mode = 1'b0;
    logic [3:0]  bsr = '0;
    logic [11:0] fsr2 = '0;
    logic [11:0] rf_addr;
    logic        rf_re;
    logic [7:0]  rf_rdata;
    logic        rf_we;
    logic [7:0]  rf_wdata;
    logic [7:0]  w_out;
    logic [2:0]  status_out;
    logic        busy;
    logic        done;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [4096];
    int          wr_cnt = 0;
    logic [11:0] last_waddr = '0;
    logic        c_model = 1'b0;
    logic        saw_illegal;

    always #2 clk = ~clk;

    rot_unit i_rot_unit (
        .clk, .rst_n, .start, .instr, .ext_mode, .bsr, .fsr2,
        .rf_addr, .rf_re, .rf_rdata, .rf_we, .rf_wdata,
        .w_out, .status_out, .busy, .done, .illegal
    );

    always @(posedge clk) begin
        if (rf_re) rf_rdata <= mem[rf_addr];
        if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
            wr_cnt       <= wr_cnt + 1;
            last_waddr   <= rf_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic exec(input logic [15:0] iw);
        @(negedge clk);
        start = 1'b1;
        instr = iw;
        @(negedge clk);
        start = 1'b0;
        saw_illegal = illegal;
        for (int k = 0; k < 10 && busy; k++) @(negedge clk);
    endtask

    function automatic logic [2:0] flags_of(input logic [7:0] r, input logic c);
        return {r[7], (r == 8'h00), c};
    endfunction

    task automatic set_carry(input logic c);
        mem[12'h001] = {7'h0, c};
        exec(16'h3001);
        c_model = c;
    endtask

    initial begin
        rf_rdata = '0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(w_out == 8'h00, "R10 W", w_out, 0);
        chk(status_out == 3'b000, "R10 status", status_out, 0);
        chk(!busy, "R10 idle", busy, 0);
        rst_n = 1'b1;

        // R2 sweep: left rotate into W, both carry values
        for (int cv = 0; cv < 2; cv++) begin
            set_carry(cv[0]);
            for (int v = 0; v < 256; v++) begin
                logic [7:0] e;
                e = {v[6:0], v[7]};
                mem[12'h003] = v[7:0];
                exec(16'h4403);
                chk(w_out == e, "R2 result", w_out, e);
                chk(status_out == flags_of(e, c_model), "R2 flags", status_out,
                    flags_of(e, c_model));
            end
        end

        // R3 sweep: right rotate through carry into W
        for (int v = 0; v < 256; v++) begin
            for (int cv = 0; cv < 2; cv++) begin
                logic [7:0] e;
                set_carry(cv[0]);
                e = {cv[0], v[7:1]};
                mem[12'h002] = v[7:0];
                exec(16'h3002);
                c_model = v[0];
                chk(w_out == e, "R3 result", w_out, e);
                chk(status_out == flags_of(e, v[0]), "R3 flags", status_out,
                    flags_of(e, v[0]));
            end
        end

        // R4: d=0 makes no write; d=1 writes back and keeps W
        begin
            int n0;
            logic [7:0] wsave;
            n0 = wr_cnt;
            mem[12'h010] = 8'hAB;
            exec(16'h4410);
            chk(wr_cnt == n0, "R4 no write for W dest", wr_cnt, n0);
            chk(w_out == 8'h57, "R4 W dest", w_out, 8'h57);
            wsave = w_out;
            set_carry(1'b0);
            wsave = w_out;
            mem[12'h011] = 8'hE6;
            exec(16'h3211);
            chk(mem[12'h011] == 8'h73, "R4 file dest", mem[12'h011], 8'h73);
            chk(status_out[0] == 1'b0, "R3 carry out", status_out[0], 0);
            chk(w_out == wsave, "R4 W held", w_out, wsave);
        end

        // R5: banked addressing over every bank number
        for (int b = 0; b < 16; b++) begin
            logic [11:0] a;
            bsr = b[3:0];
            a = {b[3:0], 8'h9C};
            mem[a] = 8'h81;
            exec(16'h479C);
            chk(mem[a] == 8'h03, "R5 banked target", mem[a], 8'h03);
            chk(last_waddr == a, "R5 banked addr", last_waddr, a);
        end
        bsr = 4'h5;

        // R6: access window, both halves and split edge
        begin
            logic [7:0] fl [4] = '{8'h00, 8'h5F, 8'h60, 8'hFF};
            for (int i = 0; i < 4; i++) begin
                logic [11:0] a;
                a = (fl[i] < 8'h60) ? {4'h0, fl[i]} : {4'hF, fl[i]};
                exec({8'h46, fl[i]});
                chk(last_waddr == a, "R6 access addr", last_waddr, a);
            end
        end

        // R7: indexed literal offset, split edge and wrap
        ext_mode = 1'b1;
        fsr2 = 12'h200;
        exec(16'h4610);
        chk(last_waddr == 12'h210, "R7 indexed", last_waddr, 12'h210);
        exec(16'h465F);
        chk(last_waddr == 12'h25F, "R7 edge 5F", last_waddr, 12'h25F);
        exec(16'h4660);
        chk(last_waddr == 12'hF60, "R7 edge 60", last_waddr, 12'hF60);
        fsr2 = 12'hFF0;
        exec(16'h4620);
        chk(last_waddr == 12'h010, "R7 wrap", last_waddr, 12'h010);
        exec(16'h4720);
        chk(last_waddr == 12'h520, "R7 banked wins", last_waddr, 12'h520);
        ext_mode = 1'b0;

        // R8: phase sequence, start held while busy is ignored
        begin
            int n0;
            n0 = wr_cnt;
            @(negedge clk); start = 1'b1; instr = 16'h4630;
            @(negedge clk);
            chk(busy && !rf_re && !rf_we, "R8 decode phase", {busy, rf_re, rf_we}, 3'b100);
            @(negedge clk);
            chk(rf_re && !rf_we && !done, "R8 read phase", {rf_re, rf_we, done}, 3'b100);
            start = 1'b0;
            @(negedge clk);
            chk(!rf_re && !rf_we && busy, "R8 process phase", {rf_re, rf_we, busy}, 3'b001);
            @(negedge clk);
            chk(rf_we && done, "R8 write phase", {rf_we, done}, 2'b11);
            @(negedge clk);
            chk(!busy, "R8 back to idle", busy, 0);
            repeat (3) @(negedge clk);
            chk(wr_cnt == n0 + 1, "R8 start ignored while busy", wr_cnt, n0 + 1);
        end

        // R9 / R1: illegal opcodes
        begin
            logic [15:0] bad [6] = '{16'h0000, 16'h4000, 16'h4800, 16'h3400,
                                     16'h3C00, 16'hFFFF};
            for (int i = 0; i < 6; i++) begin
                int n0;
                logic [7:0] w0;
                logic [2:0] s0;
                n0 = wr_cnt; w0 = w_out; s0 = status_out;
                exec(bad[i] | 16'h0300);
                chk(saw_illegal, "R9 illegal flag", saw_illegal, 1);
                chk(wr_cnt == n0 && w_out == w0 && status_out == s0, "R9 no effect",
                    w_out, w0);
            end
            exec(16'h4403);
            chk(!saw_illegal, "R1 legal not flagged", saw_illegal, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule